// File: doc/BRIEF.md
# SONET Transmit Path Overhead Generator

This block produces the three path overhead bytes that travel with every outgoing STS-1 frame: the path trace byte (J1), the path parity byte (B3) and the path status byte (G1). A single-cycle frame strobe marks each frame boundary. On that clock edge the block registers the overhead values for the frame that is starting, and they stay constant until the next strobe. The payload byte stream of the synchronous payload envelope is fed in alongside the strobe. The block folds it into a BIP-8 so that the parity of one frame is sent in the next frame.

Software-side setup goes through one byte-wide write port, which selects either a control register or a 64-entry trace store. The trace store is filled through an auto-incrementing index, and one entry is sent per frame in a repeating cycle. The G1 byte combines two things. The first is a remote error count taken from the receive side's per-frame parity error tally. The second is a remote defect code. This code can be set from register bits, or it is raised automatically for a fixed window of frames whenever a receive alarm is present. A control bit forces path AIS; while it is set, the three overhead bytes are all ones.

Top module: `poh_tx_insert`

## Requirements
- R1: After reset, `j1_out`, `b3_out` and `g1_out` are 0x00 and `ais_force` is 0. The three overhead outputs load only on a clock edge where `frm_start` is high, and hold their value on every other edge, including edges where the host writes.
- R2: At each boundary, `j1_out` takes trace entry k. k is 0 after reset, advances by one per boundary and wraps from 63 to 0. When control bit 7 (trace enable) is 0, `j1_out` is 0x00 but k still advances.
- R3: At each boundary, `b3_out` is the XOR of every `spe_byte` that had `spe_valid` high after the previous boundary edge, up to and including the boundary cycle's predecessor. A byte valid in the boundary cycle counts toward the next frame. When control bit 5 is 1, `b3_out` is 0x00.
- R4: `g1_out[7:4]` is the remote error count. When control bit 4 is 1, it is `rx_bip_errs` sampled at the boundary and saturated to 8; when the bit is 0, it is 0. `g1_out[0]` is always 0 outside AIS.
- R5: If no automatic defect window is active, `g1_out[3:1]` equals control bits [3:1] bit for bit. When control bit 0 (automatic defect) is 0, `rx_alarms` has no effect on `g1_out`.
- R6: With control bit 0 set, a boundary at which any bit of `rx_alarms` is high starts a window of HOLD_FRAMES frames: that boundary and the next HOLD_FRAMES-1 boundaries. During the window, `g1_out[3:1]` is 3'b100, overriding the register bits. An alarm seen inside a window restarts it.
- R7: Control bit 6 drives `ais_force` from the clock cycle after it is written. Every boundary taken while it is set loads 0xFF into `j1_out`, `b3_out` and `g1_out`.
- R8: With `wr_sel`=0, a write loads the control register. With `wr_sel`=1, a write stores `wr_data` at the trace write index, which is 0 after reset, increments per trace write and wraps from 63 to 0, so the 65th write replaces entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_start | input | 1 | One-cycle frame boundary strobe |
| spe_valid | input | 1 | Payload byte present on spe_byte |
| spe_byte | input | 8 | Payload byte for parity |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 selects control register, 1 selects trace store |
| wr_data | input | 8 | Host write data |
| rx_alarms | input | 7 | Receive alarms: loss of signal, loss of frame, loss of pointer, line AIS, path AIS, unequipped, payload mismatch |
| rx_bip_errs | input | ERR_W | Path parity errors counted by the receive side in the last frame |
| j1_out | output | 8 | Trace byte for the current frame |
| b3_out | output | 8 | Path parity byte for the current frame |
| g1_out | output | 8 | Path status byte for the current frame |
| ais_force | output | 1 | Path AIS request to the framer |

## Verification
The assertions assume that `frm_start` is a single-cycle pulse with several idle cycles between pulses. They also assume that `rx_alarms` and `rx_bip_errs` only matter on the boundary cycle, because the block samples them nowhere else. The bench raises the strobe for exactly one cycle after each burst of payload bytes. It presents the alarm and error values only in that cycle and clears them afterwards. Host writes are always placed between boundaries, so every ordering the bench relies on is defined by R1 and R8.

// File: rtl/poh_pkg.sv
package poh_pkg;

    localparam int TRACE_LEN  = 64;
    localparam int NUM_ALARMS = 7;
    localparam int REI_MAX    = 8;

    // code placed in the defect field while an alarm window is running
    localparam logic [2:0] RDI_FORCED = 3'b100;

    // control register, bit 7 down to bit 0
    typedef struct packed {
        logic       trace_en;
        logic       ais_ins;
        logic       b3_dis;
        logic       auto_rei;
        logic [2:0] rdi;
        logic       auto_rdi;
    } poh_ctrl_t;

endpackage

// File: rtl/poh_trace_store.sv
module poh_trace_store #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         adv,
    output logic [W-1:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
    } ts_state_t;

    ts_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[st_q.wp] = wr_data;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (adv) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.mem[st_q.rp];

    AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (st_q.rp == LAST) |=> st_q.rp == '0); // R2

    AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (st_q.wp == LAST) |=> st_q.wp == '0); // R8

endmodule

// File: rtl/poh_bip8.sv
module poh_bip8 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_vld,
    input  logic [W-1:0] byte_in,
    input  logic         frm,
    output logic [W-1:0] parity
);
    typedef struct packed {
        logic [W-1:0] acc;
    } bip_state_t;

    bip_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frm) begin
            // a byte in the boundary cycle opens the next frame
            st_d.acc = byte_vld ? byte_in : '0;
        end else if (byte_vld) begin
            st_d.acc = st_q.acc ^ byte_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign parity = st_q.acc;

    AST_BIP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frm && !byte_vld |=> parity == '0); // R3

    AST_BIP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frm && !byte_vld |=> $stable(parity)); // R3

endmodule

// File: rtl/poh_rdi_hold.sv
module poh_rdi_hold #(
    parameter int HOLD = 10,
    parameter int NA   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm,
    input  logic          enable,
    input  logic [NA-1:0] alarms,
    output logic          active
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic        any_alarm;

    assign any_alarm = |alarms;
    // this frame carries the forced code if an alarm is seen now or a window is open
    assign active    = enable && (any_alarm || (st_q.cnt != '0));

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (frm) begin
            if (any_alarm)              st_d.cnt = RELOAD;
            else if (st_q.cnt != '0)    st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= RELOAD); // R6

    AST_HOLD_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> st_q.cnt == '0); // R5

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !frm |=> $stable(st_q.cnt)); // R6

endmodule

// File: rtl/poh_tx_insert.sv
module poh_tx_insert #(
    parameter int HOLD_FRAMES = 10,
    parameter int ERR_W       = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frm_start,
    input  logic                          spe_valid,
    input  logic [7:0]                    spe_byte,
    input  logic                          wr_en,
    input  logic                          wr_sel,
    input  logic [7:0]                    wr_data,
    input  logic [poh_pkg::NUM_ALARMS-1:0] rx_alarms,
    input  logic [ERR_W-1:0]              rx_bip_errs,
    output logic [7:0]                    j1_out,
    output logic [7:0]                    b3_out,
    output logic [7:0]                    g1_out,
    output logic                          ais_force
);
    import poh_pkg::*;

    typedef struct packed {
        poh_ctrl_t  ctrl;
        logic [7:0] j1;
        logic [7:0] b3;
        logic [7:0] g1;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [7:0] trace_byte;
    logic [7:0] bip_val;
    logic       rdi_on;
    logic [3:0] rei_val;
    logic [2:0] rdi_val;
    logic       trace_wr;

    assign trace_wr = wr_en && wr_sel;

    poh_trace_store #(
        .DEPTH (TRACE_LEN),
        .W     (8)
    ) u_trace (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (trace_wr),
        .wr_data (wr_data),
        .adv     (frm_start),
        .rd_data (trace_byte)
    );

    poh_bip8 #(
        .W (8)
    ) u_bip (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (spe_valid),
        .byte_in  (spe_byte),
        .frm      (frm_start),
        .parity   (bip_val)
    );

    poh_rdi_hold #(
        .HOLD (HOLD_FRAMES),
        .NA   (NUM_ALARMS)
    ) u_rdi (
        .clk    (clk),
        .rst_n  (rst_n),
        .frm    (frm_start),
        .enable (st_q.ctrl.auto_rdi),
        .alarms (rx_alarms),
        .active (rdi_on)
    );

    // remote error count, clipped at the largest legal code
    always_comb begin
        if (!st_q.ctrl.auto_rei)
            rei_val = 4'd0;
        else if (32'(rx_bip_errs) > 32'(REI_MAX))
            rei_val = 4'(REI_MAX);
        else
            rei_val = 4'(rx_bip_errs);
    end

    assign rdi_val = rdi_on ? RDI_FORCED : st_q.ctrl.rdi;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_sel) begin
            st_d.ctrl = poh_ctrl_t'(wr_data);
        end
        if (frm_start) begin
            if (st_q.ctrl.ais_ins) begin
                st_d.j1 = 8'hFF;
                st_d.b3 = 8'hFF;
                st_d.g1 = 8'hFF;
            end else begin
                st_d.j1 = st_q.ctrl.trace_en ? trace_byte : 8'h00;
                st_d.b3 = st_q.ctrl.b3_dis   ? 8'h00      : bip_val;
                st_d.g1 = {rei_val, rdi_val, 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign j1_out    = st_q.j1;
    assign b3_out    = st_q.b3;
    assign g1_out    = st_q.g1;
    assign ais_force = st_q.ctrl.ais_ins;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_start |=> $stable(j1_out) && $stable(b3_out) && $stable(g1_out)); // R1

    AST_TRACE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start && !ais_force && !st_q.ctrl.trace_en |=> j1_out == 8'h00); // R2

    AST_B3_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start && !ais_force && st_q.ctrl.b3_dis |=> b3_out == 8'h00); // R3

    AST_REI_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start && !ais_force |=> (g1_out[7:4] <= 4'd8) && !g1_out[0]); // R4

    AST_RDI_ON_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start && !ais_force && st_q.ctrl.auto_rdi && (|rx_alarms)
        |=> g1_out[3:1] == RDI_FORCED); // R6

    AST_AIS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start && ais_force
        |=> (j1_out == 8'hFF) && (b3_out == 8'hFF) && (g1_out == 8'hFF)); // R7

endmodule

// File: tb/sim_poh_tx_insert.sv
module sim_poh_tx_insert;

    localparam int HOLD  = 10;
    localparam int ERR_W = 4;

    // {control, error count, expected G1}
    localparam logic [19:0] VECS [8] = '{
        20'h80_3_00, 20'h90_3_30, 20'h90_8_80, 20'h90_D_80,
        20'h9E_0_0E, 20'h08_5_08, 20'hA4_2_04, 20'h13_1_12
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             frm_start;
    logic             spe_valid;
    logic [7:0]       spe_byte;
    logic             wr_en;
    logic             wr_sel;
    logic [7:0]       wr_data;
    logic [6:0]       rx_alarms;
    logic [ERR_W-1:0] rx_bip_errs;
    logic [7:0]       j1_out, b3_out, g1_out;
    logic             ais_force;

    int         n_tests = 0;
    int         n_fail  = 0;
    int         frame_idx = 0;
    logic [7:0] ctrl_m = 8'h00;
    logic [7:0] exp_bip = 8'h00;
    logic [7:0] tmem [64];

    poh_tx_insert #(.HOLD_FRAMES(HOLD), .ERR_W(ERR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
        .spe_valid(spe_valid), .spe_byte(spe_byte),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rx_alarms(rx_alarms), .rx_bip_errs(rx_bip_errs),
        .j1_out(j1_out), .b3_out(b3_out), .g1_out(g1_out),
        .ais_force(ais_force)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h (frame %0d)",
                     req, what, act, exp, frame_idx);
        end
    endtask

    task automatic host_wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (!sel) ctrl_m = d;
    endtask

    // payload burst, then one boundary; J1 and B3 are checked every frame
    task automatic do_frame(input int n, input int seed,
                            input logic [6:0] al, input logic [ERR_W-1:0] e);
        logic [7:0] ej1, eb3;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            spe_valid = 1'b1;
            spe_byte  = 8'(seed + i * 13);
            exp_bip   = exp_bip ^ spe_byte;
        end
        @(negedge clk);
        spe_valid = 1'b0;
        frm_start = 1'b1; rx_alarms = al; rx_bip_errs = e;
        if (ctrl_m[6]) begin
            ej1 = 8'hFF; eb3 = 8'hFF;
        end else begin
            ej1 = ctrl_m[7] ? tmem[frame_idx % 64] : 8'h00;
            eb3 = ctrl_m[5] ? 8'h00 : exp_bip;
        end
        @(negedge clk);
        frm_start = 1'b0; rx_alarms = '0; rx_bip_errs = '0;
        frame_idx++;
        exp_bip = 8'h00;
        chk(ctrl_m[6] ? "R7" : "R2", "J1", j1_out, ej1);
        chk(ctrl_m[6] ? "R7" : "R3", "B3", b3_out, eb3);
    endtask

    initial begin
        #1_500_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; frm_start = 1'b0; spe_valid = 1'b0; spe_byte = '0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        rx_alarms = '0; rx_bip_errs = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "J1 reset", j1_out, 8'h00);
        chk("R1", "B3 reset", b3_out, 8'h00);
        chk("R1", "G1 reset", g1_out, 8'h00);
        chk("R1", "AIS reset", {7'd0, ais_force}, 8'h00);

        // R8 fill the trace store through the auto-incrementing index
        for (int i = 0; i < 64; i++) begin
            tmem[i] = 8'(i * 7 + 3);
            host_wr(1'b1, tmem[i]);
        end

        // vector table: R2 R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            host_wr(1'b0, VECS[v][19:12]);
            do_frame(3 + v, v * 17, 7'h00, VECS[v][11:8]);
            chk("R4/R5", "G1 table", g1_out, VECS[v][7:0]);
        end

        // R1 host write between boundaries leaves outputs alone
        host_wr(1'b0, 8'h9E);
        chk("R1", "G1 after write", g1_out, 8'h12);
        do_frame(4, 99, 7'h00, 4'd0);
        chk("R5", "G1 new rdi", g1_out, 8'h0E);

        // R6 each alarm alone opens a window of HOLD frames
        host_wr(1'b0, 8'h0B);
        for (int k = 0; k < 7; k++) begin
            do_frame(2, k, 7'(1 << k), 4'd0);
            chk("R6", "G1 alarm start", g1_out, 8'h08);
            for (int j = 1; j < HOLD; j++) begin
                do_frame(1, j, 7'h00, 4'd0);
                if (j == HOLD - 1) chk("R6", "G1 window end", g1_out, 8'h08);
            end
            do_frame(1, k, 7'h00, 4'd0);
            chk("R6", "G1 after window", g1_out, 8'h0A);
        end

        // R6 alarm inside a window restarts it
        do_frame(1, 5, 7'h04, 4'd0);
        for (int j = 0; j < 4; j++) do_frame(1, j, 7'h00, 4'd0);
        do_frame(1, 6, 7'h40, 4'd0);
        for (int j = 1; j < HOLD; j++) do_frame(1, j, 7'h00, 4'd0);
        chk("R6", "G1 restarted window", g1_out, 8'h08);
        do_frame(1, 7, 7'h00, 4'd0);
        chk("R6", "G1 restart expiry", g1_out, 8'h0A);

        // R5 alarms ignored with automatic defect off
        host_wr(1'b0, 8'h0A);
        do_frame(2, 3, 7'h7F, 4'd0);
        chk("R5", "G1 alarms ignored", g1_out, 8'h0A);

        // R7 AIS
        host_wr(1'b0, 8'h40);
        chk("R7", "ais_force set", {7'd0, ais_force}, 8'h01);
        do_frame(3, 1, 7'h00, 4'd5);
        chk("R7", "G1 AIS", g1_out, 8'hFF);
        host_wr(1'b0, 8'h00);
        chk("R7", "ais_force clear", {7'd0, ais_force}, 8'h00);
        do_frame(3, 2, 7'h00, 4'd5);
        chk("R7", "G1 after AIS", g1_out, 8'h00);

        // R2 read index wraps; R8 65th write lands in entry 0
        host_wr(1'b0, 8'h80);
        while (frame_idx % 64 != 0) do_frame(1, frame_idx, 7'h00, 4'd0);
        host_wr(1'b1, 8'hA5);
        tmem[0] = 8'hA5;
        do_frame(2, 8, 7'h00, 4'd0);
        chk("R8", "J1 overwritten entry", j1_out, 8'hA5);
        do_frame(2, 9, 7'h00, 4'd0);
        chk("R2", "J1 after wrap", j1_out, tmem[1]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule